// File: doc/BRIEF.md
# UART Interrupt Identification Arbiter

This block sits beside the register file of a 16550-style serial port. It takes the interrupt enables, the receiver error flags, the receive FIFO fill state, the character-timeout flag and the modem-status change flags. From these it picks the single most urgent pending cause. It drives the identification byte that software reads, and one level-sensitive interrupt request line.

Most sources are plain levels owned by other blocks. The transmit-holding-empty cause is different, because it is an event that software acknowledges. The block therefore keeps its own pending flag for that cause. The flag is armed when the transmit path drains and when its enable bit is switched on over an empty holding register. It is disarmed by an identification read that reports this cause, or when its enable is switched off.

The identification byte and the request line are derived combinationally from the current inputs and the pending flag, so they follow a source change in the same cycle. The only state in the block is the pending flag, which changes on a clock edge.

Top module: `uart_int_arbiter`

## Requirements
- R1: When several causes are pending at once, only the most urgent is reported. The order, from most to least urgent, is: receiver line error, character timeout, receive data available, transmit holding empty, modem status change.
- R2: The identification byte's bits 3:0 carry the cause code: 0x6 for line error, 0xC for timeout, 0x4 for receive data, 0x2 for transmit empty, 0x0 for modem status, and 0x1 when no cause is pending. Bits 5:4 always read 0.
- R3: A line-error cause needs enable bit 2 plus at least one set bit of the 4-bit error vector (overrun, parity, framing, break, in any combination).
- R4: A receive-data cause needs enable bit 0 and `rx_ready`. In addition, either the FIFO is off, or `rx_count` is greater than or equal to `rx_trig`.
- R5: The character-timeout cause has no enable of its own. It is gated by enable bit 0, the receive-data enable.
- R6: A pulse on `id_rd` in a cycle where the reported code is 0x2 clears the transmit-empty pending flag. A read while another code is reported leaves the flag as it was.
- R7: A pulse on `en_wr` whose `en_wdata` bit 1 is 0 clears the transmit-empty pending flag. A write that takes bit 1 from 0 to 1 while `thr_empty` is high sets the flag. A write that keeps bit 1 at 1 leaves the flag unchanged.
- R8: A `thr_drained` pulse sets the pending flag only while enable bit 1 is already set, and is ignored otherwise. Within one cycle an enable write overrides a read, and a read clear overrides a drain.
- R9: Bits 7:6 of the identification byte read 11 while `fifo_on` is high and 00 otherwise.
- R10: `irq` is high exactly when bits 3:0 of the identification byte differ from 0x1.
- R11: Outputs follow their inputs within the same cycle. After reset the pending flag is clear, so with all inputs low the byte reads 0x01 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| en_q | input | 4 | Current interrupt enables: bit0 receive data, bit1 transmit empty, bit2 line error, bit3 modem status |
| en_wr | input | 1 | One-cycle strobe: the enable register is being written this cycle |
| en_wdata | input | 4 | Value being written to the enable register |
| rx_ready | input | 1 | Receive data ready |
| line_err | input | 4 | Overrun, parity, framing and break flags |
| fifo_on | input | 1 | FIFOs enabled |
| rx_count | input | CNT_W | Receive FIFO fill level |
| rx_trig | input | CNT_W | Receive FIFO trigger level |
| rx_timeout | input | 1 | Character timeout pending |
| msr_delta | input | 4 | Modem-status change flags |
| thr_empty | input | 1 | Transmit holding register / FIFO is empty |
| thr_drained | input | 1 | One-cycle pulse: the transmit path has just become empty |
| id_rd | input | 1 | One-cycle strobe: the identification byte is being read |
| id_byte | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the enable register owner loads `en_wdata` into `en_q` on the edge that ends an `en_wr` cycle. They also assume `id_rd` and `en_wr` never coincide, and that `thr_drained` only pulses while `thr_empty` is high. The bench models the enable register itself, updating it from each write strobe on the next edge. Its randomized traffic never issues a read and a write in the same cycle, and it raises the drain pulse only together with an empty holding register. Directed phases cover each priority step, the trigger-level boundary and every way of arming and clearing the pending flag.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int SRC_N = 5;

  // Source slots, index 0 is most urgent
  localparam int S_LSR = 0;
  localparam int S_TMO = 1;
  localparam int S_RXD = 2;
  localparam int S_THR = 3;
  localparam int S_MSR = 4;

  // Enable bit positions
  localparam int EN_RXD = 0;
  localparam int EN_THR = 1;
  localparam int EN_LSR = 2;
  localparam int EN_MSR = 3;

  localparam logic [3:0] CODE_NONE = 4'h1;

  function automatic logic [3:0] src_code(input int idx);
    case (idx)
      S_LSR:   return 4'h6;
      S_TMO:   return 4'hC;
      S_RXD:   return 4'h4;
      S_THR:   return 4'h2;
      default: return 4'h0;
    endcase
  endfunction
endpackage

// File: rtl/uirq_src_eval.sv
module uirq_src_eval
  import uirq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [3:0]       en_q,
  input  logic             rx_ready,
  input  logic [3:0]       line_err,
  input  logic             fifo_on,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             rx_timeout,
  input  logic [3:0]       msr_delta,
  input  logic             thr_pend,
  output logic [SRC_N-1:0] req
);
  logic at_trig;

  assign at_trig = !fifo_on || (rx_count >= rx_trig);

  always_comb begin
    req        = '0;
    req[S_LSR] = en_q[EN_LSR] && (|line_err);
    req[S_TMO] = en_q[EN_RXD] && rx_timeout;
    req[S_RXD] = en_q[EN_RXD] && rx_ready && at_trig;
    req[S_THR] = en_q[EN_THR] && thr_pend;
    req[S_MSR] = en_q[EN_MSR] && (|msr_delta);
  end
endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  logic [N:0] blocked;

  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_lvl
    assign grant[i]     = req[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | req[i];
  end

  assign any = blocked[N];
endmodule

// File: rtl/uirq_code_mux.sv
module uirq_code_mux
  import uirq_pkg::*;
(
  input  logic [SRC_N-1:0] grant,
  input  logic             fifo_on,
  output logic [7:0]       id_byte
);
  logic [3:0] low;

  always_comb begin
    low = CODE_NONE;
    for (int i = 0; i < SRC_N; i++) begin
      if (grant[i]) low = src_code(i);
    end
  end

  assign id_byte = {{2{fifo_on}}, 2'b00, low};
endmodule

// File: rtl/uirq_thr_latch.sv
module uirq_thr_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic en_thr,
  input  logic en_wr,
  input  logic wr_thr,
  input  logic thr_empty,
  input  logic thr_drained,
  input  logic id_rd,
  input  logic thr_shown,
  output logic pend
);
  logic pend_q;
  logic pend_nxt;
  logic upd;

  // Later assignments override: write > read clear > drain
  always_comb begin
    pend_nxt = pend_q;
    if (thr_drained && en_thr) pend_nxt = 1'b1;
    if (id_rd && thr_shown)    pend_nxt = 1'b0;
    if (en_wr) begin
      if (!wr_thr)                    pend_nxt = 1'b0;
      else if (!en_thr && thr_empty)  pend_nxt = 1'b1;
    end
  end

  assign upd = en_wr | id_rd | thr_drained;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= 1'b0;
    else if (upd) pend_q <= pend_nxt;
  end

  assign pend = pend_q;
endmodule

// File: rtl/uart_int_arbiter.sv
module uart_int_arbiter
  import uirq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       en_q,
  input  logic             en_wr,
  input  logic [3:0]       en_wdata,
  input  logic             rx_ready,
  input  logic [3:0]       line_err,
  input  logic             fifo_on,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             rx_timeout,
  input  logic [3:0]       msr_delta,
  input  logic             thr_empty,
  input  logic             thr_drained,
  input  logic             id_rd,
  output logic [7:0]       id_byte,
  output logic             irq
);
  logic [SRC_N-1:0] req;
  logic [SRC_N-1:0] grant;
  logic             thr_pend;

  uirq_src_eval #(.CNT_W(CNT_W)) u_src (
    .en_q(en_q), .rx_ready(rx_ready), .line_err(line_err), .fifo_on(fifo_on),
    .rx_count(rx_count), .rx_trig(rx_trig), .rx_timeout(rx_timeout),
    .msr_delta(msr_delta), .thr_pend(thr_pend), .req(req)
  );

  uirq_prio_enc #(.N(SRC_N)) u_prio (
    .req(req), .grant(grant), .any(irq)
  );

  uirq_code_mux u_mux (
    .grant(grant), .fifo_on(fifo_on), .id_byte(id_byte)
  );

  uirq_thr_latch u_thr (
    .clk(clk), .rst_n(rst_n), .en_thr(en_q[EN_THR]), .en_wr(en_wr),
    .wr_thr(en_wdata[EN_THR]), .thr_empty(thr_empty),
    .thr_drained(thr_drained), .id_rd(id_rd),
    .thr_shown(grant[S_THR]), .pend(thr_pend)
  );
endmodule

// File: rtl/uart_int_arbiter_chk.sv
module uart_int_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] en_q,
  input logic       en_wr,
  input logic [3:0] en_wdata,
  input logic [3:0] line_err,
  input logic       fifo_on,
  input logic [3:0] msr_delta,
  input logic       thr_empty,
  input logic       thr_drained,
  input logic       id_rd,
  input logic [7:0] id_byte,
  input logic       irq
);
  assert_irq_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (id_byte[3:0] != 4'h1));

  assert_upper_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (id_byte[7:6] == {2{fifo_on}}) && (id_byte[5:4] == 2'b00));

  assert_line_err_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[2] && (|line_err)) |-> (id_byte[3:0] == 4'h6));

  assert_modem_raises_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[3] && (|msr_delta)) |-> irq);

  assert_timeout_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[0] |-> ((id_byte[3:0] != 4'hC) && (id_byte[3:0] != 4'h4)));

  assert_read_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rd && !en_wr && !thr_drained && id_byte[3:0] == 4'h2)
      |=> (id_byte[3:0] != 4'h2));

  assert_en_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && !en_wdata[1]) |=> (id_byte[3:0] != 4'h2));

  assert_en_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && en_wdata[1] && !en_q[1] && thr_empty) |=> irq);
endmodule

bind uart_int_arbiter uart_int_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .en_wr(en_wr), .en_wdata(en_wdata),
  .line_err(line_err), .fifo_on(fifo_on), .msr_delta(msr_delta),
  .thr_empty(thr_empty), .thr_drained(thr_drained), .id_rd(id_rd),
  .id_byte(id_byte), .irq(irq)
);

// File: tb/uart_int_arbiter_bench.sv
`timescale 1ns/1ps
module uart_int_arbiter_bench;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [3:0]    en_q;
  logic          en_wr = 0;
  logic [3:0]    en_wdata = 0;
  logic          rx_ready = 0;
  logic [3:0]    line_err = 0;
  logic          fifo_on = 0;
  logic [CW-1:0] rx_count = 0;
  logic [CW-1:0] rx_trig = 1;
  logic          rx_timeout = 0;
  logic [3:0]    msr_delta = 0;
  logic          thr_empty = 0;
  logic          thr_drained = 0;
  logic          id_rd = 0;
  logic [7:0]    id_byte;
  logic          irq;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    m_pend;
  bit    running = 0;
  string cur_req = "R11";

  always #10 clk = ~clk;

  uart_int_arbiter #(.CNT_W(CW)) u_uart_int_arbiter (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .en_wr(en_wr), .en_wdata(en_wdata),
    .rx_ready(rx_ready), .line_err(line_err), .fifo_on(fifo_on),
    .rx_count(rx_count), .rx_trig(rx_trig), .rx_timeout(rx_timeout),
    .msr_delta(msr_delta), .thr_empty(thr_empty), .thr_drained(thr_drained),
    .id_rd(id_rd), .id_byte(id_byte), .irq(irq)
  );

  // Behavioural expectation of the identification byte
  function automatic logic [7:0] expect_byte(bit pend);
    int code;
    if (en_q[2] && line_err != 0)                                          code = 'h6;
    else if (en_q[0] && rx_timeout)                                        code = 'hC;
    else if (en_q[0] && rx_ready && (!fifo_on || int'(rx_count) >= int'(rx_trig))) code = 'h4;
    else if (en_q[1] && pend)                                              code = 'h2;
    else if (en_q[3] && msr_delta != 0)                                    code = 'h0;
    else                                                                   code = 'h1;
    return {fifo_on, fifo_on, 2'b00, 4'(code)};
  endfunction

  // Reference model of the pending flag and of the enable register owner
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 1'b0;
      en_q  <= 4'h0;
    end else begin
      bit nxt;
      logic [7:0] shown;
      shown = expect_byte(m_pend);
      nxt = m_pend;
      if (thr_drained && en_q[1]) nxt = 1'b1;
      if (id_rd && shown[3:0] == 4'h2) nxt = 1'b0;
      if (en_wr) begin
        if (!en_wdata[1]) nxt = 1'b0;
        else if (!en_q[1] && thr_empty) nxt = 1'b1;
      end
      m_pend = nxt;
      if (en_wr) en_q <= en_wdata;
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && running) begin
      logic [7:0] e;
      e = expect_byte(m_pend);
      n_chk++;
      if (id_byte !== e || irq !== (e[3:0] != 4'h1)) begin
        n_bad++;
        $display("FAIL %s: id_byte=%02h irq=%0b expected %02h irq=%0b",
                 cur_req, id_byte, irq, e, (e[3:0] != 4'h1));
      end
    end
  end

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr_en(logic [3:0] v);
    en_wr = 1; en_wdata = v; cyc(); en_wr = 0;
  endtask

  task automatic rd_id();
    id_rd = 1; cyc(); id_rd = 0;
  endtask

  task automatic drain();
    thr_empty = 1; thr_drained = 1; cyc(); thr_drained = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 0;
    cyc(3);
    // R11: reset state
    @(negedge clk);
    n_chk++;
    if (id_byte !== 8'h01 || irq !== 1'b0) begin
      n_bad++;
      $display("FAIL R11: reset id_byte=%02h irq=%0b expected 01 irq=0", id_byte, irq);
    end
    @(posedge clk); #1;
    rst_n = 1;
    running = 1;
    cyc(2);

    // R1/R2: stack every cause and peel them away
    cur_req = "R1";
    thr_empty = 1;
    wr_en(4'hF);
    line_err = 4'b0001; rx_timeout = 1; rx_ready = 1; msr_delta = 4'b0010;
    cyc(2);
    cur_req = "R2"; line_err = 0;   cyc(2);
    rx_timeout = 0;                 cyc(2);
    rx_ready = 0;                   cyc(2);
    rd_id();                        cyc(2);
    msr_delta = 0;                  cyc(2);

    // R3: each error bit, with and without enable
    cur_req = "R3";
    for (int b = 0; b < 4; b++) begin
      line_err = 4'(1 << b); cyc();
    end
    wr_en(4'b1011); cyc();
    line_err = 4'b1010; cyc(2);
    line_err = 0;
    wr_en(4'hF);

    // R4: trigger level boundary
    cur_req = "R4";
    fifo_on = 1; rx_trig = 5'd4; rx_ready = 1;
    rx_count = 5'd3; cyc(2);
    rx_count = 5'd4; cyc(2);
    rx_count = 5'd5; cyc(2);
    rx_ready = 0;    cyc(2);
    fifo_on = 0; rx_ready = 1; rx_count = 0; cyc(2);
    rx_ready = 0;

    // R5: timeout follows receive-data enable
    cur_req = "R5";
    rx_timeout = 1; cyc(2);
    wr_en(4'b1110); cyc(2);
    wr_en(4'hF); rx_timeout = 0; cyc();

    // R6: read clears only when transmit-empty is shown
    cur_req = "R6";
    drain(); cyc();
    rx_ready = 1; rd_id(); rx_ready = 0; cyc(2);
    rd_id(); cyc(2);

    // R7: enable write arming and disarming
    cur_req = "R7";
    wr_en(4'hF); cyc(2);
    thr_empty = 0; wr_en(4'h0); wr_en(4'h2); cyc(2);
    thr_empty = 1; wr_en(4'h0); wr_en(4'h2); cyc(2);
    wr_en(4'h0); cyc(2);

    // R8: drain gated by enable, precedence
    cur_req = "R8";
    drain(); cyc(2);
    wr_en(4'h2); rd_id(); cyc();
    drain(); cyc(2);
    id_rd = 1; thr_drained = 1; cyc(); id_rd = 0; thr_drained = 0; cyc(2);

    // R9/R10: FIFO flag on the upper bits
    cur_req = "R9";
    fifo_on = 1; cyc(2); fifo_on = 0; cyc(2);

    // Mixed traffic
    cur_req = "R10";
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = $urandom_range(0, 9);
      line_err   = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0;
      rx_timeout = ($urandom_range(0, 4) == 0);
      rx_ready   = $urandom_range(0, 1);
      fifo_on    = $urandom_range(0, 1);
      rx_count   = 5'($urandom_range(0, 16));
      rx_trig    = 5'($urandom_range(1, 14));
      msr_delta  = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
      thr_empty  = $urandom_range(0, 1);
      en_wr = 0; id_rd = 0; thr_drained = 0;
      if (k == 0) begin en_wr = 1; en_wdata = 4'($urandom); end
      else if (k < 4) id_rd = 1;
      if (k > 6) begin thr_empty = 1; thr_drained = 1; end
      cyc();
    end
    en_wr = 0; id_rd = 0; thr_drained = 0;
    cyc(2);
    running = 0;
    finish_run();
  end
endmodule